// File: doc/BRIEF.md
# Multiplexed Address/Data Memory Bus Controller

This block sits between the data-memory port of an 8-bit processor and an external SRAM. The SRAM is wired through a transparent address latch. The low address byte and the data byte share one 8-bit bus. The upper address bits go out on a separate bus, and the number of those bits actually driven is programmable. A latch-enable output, an active-low read strobe and an active-low write strobe complete the bus.

Each accepted request is classed as internal or external by comparing its address with a fixed internal-memory limit. While the interface is enabled, every access runs an address phase on the bus. An internal access then runs one quiet data cycle with both strobes held high. An external access holds its strobe for one cycle plus a number of wait cycles. The wait count is chosen per sector: addresses at or above a programmable split point use one setting, and lower addresses use the other. A compatibility mode collapses the space to one sector, allows only zero or one wait cycle, drives every upper address bit and disables the bus keeper.

The processor sees a stall signal for the whole of an external access. Read data appears on a held output once the stall drops.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, latch enable is low, both strobes are high, the shared bus is not driven, stall is low and the captured read data is zero.
- R2: With the interface enabled, a request whose address is above the internal limit (default 0x10FF) runs an external cycle with a strobe; an address at or below the limit runs an internal cycle with no strobe.
- R3: In the cycle after a request is accepted, latch enable is high for exactly one cycle, the shared bus drives address bits 7:0, and the upper bus shows address bits 15:8 masked to the enabled width. Latch enable falls while that address is still on the bus.
- R4: During the strobe phase of a write, latch enable is low, the shared bus drives the write data, and the write strobe is low for 1+N consecutive cycles.
- R5: The shared bus is never driven while the read strobe is low. The read strobe stays low for 1+N cycles, and the read data output takes the value on the bus input during the last strobe cycle.
- R6: Outside compatibility mode, N is the high-sector wait setting when the address is greater than or equal to the split address, and the low-sector setting otherwise.
- R7: Stall is high from the address phase through the last strobe cycle of an external access and low in the following turnaround cycle. The turnaround cycle has both strobes high and the shared bus released.
- R8: An internal access with the interface enabled drives the address phase and one data cycle (write data on writes), keeps both strobes high and never raises stall.
- R9: With the interface disabled, a request at any address produces no bus cycle: latch enable low, strobes high, shared bus and upper bus undriven, stall low, and the pin-override output low.
- R10: In compatibility mode, N is bit 0 of the low-sector setting for every address, and all 8 upper address bits are driven.
- R11: Outside compatibility mode, the upper-bus enable has its lowest k bits set, where k is the configured width clamped to 8. Upper address bits outside those k are driven as zero.
- R12: When the shared bus is released, it keeps showing the last value driven on it. The keeper indication is high exactly when the interface is enabled, the keeper is requested, compatibility mode is off and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Interface enable |
| cfgCompat | input | 1 | Compatibility mode |
| cfgKeeper | input | 1 | Bus keeper request |
| cfgSplitAddr | input | 16 | First address of the high sector |
| cfgWaitLo | input | 2 | Wait cycles, low sector |
| cfgWaitHi | input | 2 | Wait cycles, high sector |
| cfgHiBits | input | 4 | Number of upper address bits driven (0..8) |
| cpuReq | input | 1 | Access request, sampled when idle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Access address |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Captured read data |
| cpuStall | output | 1 | Processor stall |
| adOut | output | 8 | Shared address/data bus, output value |
| adOe | output | 1 | Shared bus output enable |
| adIn | input | 8 | Shared bus input value |
| adKeep | output | 1 | Bus keeper active |
| hiAddr | output | 8 | Upper address bus |
| hiOe | output | 8 | Per-bit upper address output enable |
| ale | output | 1 | Address latch enable (active high) |
| rdN | output | 1 | Read strobe (active low) |
| wrN | output | 1 | Write strobe (active low) |
| portOverride | output | 1 | Interface owns the pin directions |

## Verification
The hardest situations to reach from the ports are the sector-boundary and clamping combinations. One example is an address one below the split point paired with different low and high wait settings. Another is a compatibility-mode access where the low setting has bit 1 set, which must still give one wait cycle at most. The bench sweeps every pair of wait settings in both modes against a set of addresses on both sides of the internal limit and the split point. It sweeps the upper-width setting past 8 alongside them. The expected strobe length, masks and read data are computed arithmetically for each case.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_STROBE, ST_END} busState_t;

  typedef struct packed {
    logic load;       // capture request into the datapath
    logic aleOn;      // latch enable phase
    logic driveAddr;  // low address on shared bus
    logic driveData;  // write data on shared bus
    logic rdOn;       // read strobe active
    logic wrOn;       // write strobe active
    logic capture;    // sample shared bus into read register
  } busCtrl_t;
endpackage

// File: rtl/xbus_ctrl_fsm.sv
module xbus_ctrl_fsm
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned INT_LIMIT = 'h10FF,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgCompat,
  input  logic [ADDR_W-1:0] cfgSplitAddr,
  input  logic [WAIT_W-1:0] cfgWaitLo,
  input  logic [WAIT_W-1:0] cfgWaitHi,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  output busCtrl_t          ctrl,
  output logic              cpuStall
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(INT_LIMIT);
  localparam int RUN_W = WAIT_W + 2;

  busState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLoad;
  logic              isExt;
  logic              isWrite;
  logic              reqExt;
  logic              accept;

  assign reqExt = cpuAddr > LIMIT;
  assign accept = (state == ST_IDLE) && cpuReq && cfgEnable;

  always_comb begin
    if (cfgCompat)
      waitLoad = WAIT_W'(cfgWaitLo[0]);
    else if (cpuAddr >= cfgSplitAddr)
      waitLoad = cfgWaitHi;
    else
      waitLoad = cfgWaitLo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      isExt   <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_ADDR;
          isExt   <= reqExt;
          isWrite <= cpuWe;
          waitCnt <= reqExt ? waitLoad : '0;
        end
        ST_ADDR: state <= ST_STROBE;
        ST_STROBE: begin
          if (waitCnt == '0) state <= ST_END;
          else waitCnt <= waitCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl           = '0;
    ctrl.load      = accept;
    ctrl.aleOn     = (state == ST_ADDR);
    ctrl.driveAddr = (state == ST_ADDR);
    ctrl.driveData = (state == ST_STROBE) && isWrite;
    ctrl.rdOn      = (state == ST_STROBE) && isExt && !isWrite;
    ctrl.wrOn      = (state == ST_STROBE) && isExt && isWrite;
    ctrl.capture   = (state == ST_STROBE) && isExt && !isWrite && (waitCnt == '0);
  end

  assign cpuStall = isExt && ((state == ST_ADDR) || (state == ST_STROBE));

  // strobe run length, observed by the compatibility-mode check
  logic [RUN_W-1:0] strobeRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeRun <= '0;
    else if (ctrl.rdOn || ctrl.wrOn) begin
      if (strobeRun != '1) strobeRun <= strobeRun + 1'b1;
    end else strobeRun <= '0;
  end

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.rdOn && ctrl.wrOn));
  p_internal_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !isExt) |-> (!ctrl.rdOn && !ctrl.wrOn && !cpuStall));
  p_end_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_END) |-> (!cpuStall && !ctrl.rdOn && !ctrl.wrOn));
  p_stall_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuStall) |-> ctrl.aleOn);
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && state == ST_IDLE) |=> (state == ST_IDLE));
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.aleOn |=> !ctrl.aleOn);
  p_compat_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgCompat |-> (strobeRun <= RUN_W'(2)));
endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HB_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  busCtrl_t            ctrl,
  input  logic                cfgEnable,
  input  logic                cfgCompat,
  input  logic                cfgKeeper,
  input  logic [HB_W-1:0]     cfgHiBits,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [7:0]          cpuWdata,
  input  logic [7:0]          adIn,
  output logic [7:0]          adOut,
  output logic                adOe,
  output logic                adKeep,
  output logic [ADDR_W-9:0]   hiAddr,
  output logic [ADDR_W-9:0]   hiOe,
  output logic [7:0]          cpuRdata
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        dataReg;
  logic [7:0]        keepReg;
  logic [7:0]        rdReg;
  logic [7:0]        drvVal;
  logic [HI_W-1:0]   hiMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      keepReg <= '0;
      rdReg   <= '0;
    end else begin
      if (ctrl.load) begin
        addrReg <= cpuAddr;
        dataReg <= cpuWdata;
      end
      if (adOe) keepReg <= drvVal;
      if (ctrl.capture) rdReg <= adIn;
    end
  end

  assign drvVal = ctrl.driveAddr ? addrReg[7:0] : dataReg;
  assign adOe   = ctrl.driveAddr || ctrl.driveData;
  assign adOut  = adOe ? drvVal : keepReg;
  assign adKeep = cfgEnable && cfgKeeper && !cfgCompat && !adOe;

  for (genvar g = 0; g < HI_W; g++) begin : g_hiMask
    assign hiMask[g] = cfgCompat || (cfgHiBits > HB_W'(g));
  end

  assign hiOe     = cfgEnable ? hiMask : '0;
  assign hiAddr   = addrReg[ADDR_W-1:8] & hiMask;
  assign cpuRdata = rdReg;

  p_read_float_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rdOn |-> !adOe);
  p_ale_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.aleOn |-> (adOe && adOut == addrReg[7:0]));
  p_keep_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!adOe && $past(!adOe)) |-> $stable(adOut));
  p_hi_contig_r11: assert property (@(posedge clk) disable iff (!rstN)
    (((hiOe + 1'b1) & hiOe) == '0));
  p_hi_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((hiAddr & ~hiMask) == '0));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned INT_LIMIT = 'h10FF,
  parameter int WAIT_W = 2,
  parameter int HB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgCompat,
  input  logic              cfgKeeper,
  input  logic [ADDR_W-1:0] cfgSplitAddr,
  input  logic [WAIT_W-1:0] cfgWaitLo,
  input  logic [WAIT_W-1:0] cfgWaitHi,
  input  logic [HB_W-1:0]   cfgHiBits,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuStall,
  output logic [7:0]        adOut,
  output logic              adOe,
  input  logic [7:0]        adIn,
  output logic              adKeep,
  output logic [ADDR_W-9:0] hiAddr,
  output logic [ADDR_W-9:0] hiOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              portOverride
);
  busCtrl_t ctrl;

  xbus_ctrl_fsm #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT), .WAIT_W(WAIT_W)) i_fsm (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgCompat(cfgCompat),
    .cfgSplitAddr(cfgSplitAddr), .cfgWaitLo(cfgWaitLo), .cfgWaitHi(cfgWaitHi),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .ctrl(ctrl), .cpuStall(cpuStall)
  );

  xbus_datapath #(.ADDR_W(ADDR_W), .HB_W(HB_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfgEnable(cfgEnable),
    .cfgCompat(cfgCompat), .cfgKeeper(cfgKeeper), .cfgHiBits(cfgHiBits),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .adKeep(adKeep),
    .hiAddr(hiAddr), .hiOe(hiOe), .cpuRdata(cpuRdata)
  );

  assign ale          = ctrl.aleOn;
  assign rdN          = !ctrl.rdOn;
  assign wrN          = !ctrl.wrOn;
  assign portOverride = cfgEnable;

  p_override_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> (!ale && rdN && wrN && !adOe && hiOe == '0));
endmodule

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgCompat = 1'b0, cfgKeeper = 1'b0;
  logic [15:0] cfgSplitAddr = 16'h8000;
  logic [1:0] cfgWaitLo = '0, cfgWaitHi = '0;
  logic [3:0] cfgHiBits = '0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, adIn = '0;
  logic [7:0] cpuRdata, adOut, hiAddr, hiOe;
  logic cpuStall, adOe, adKeep, ale, rdN, wrN, portOverride;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xbus_ctrl i_xbus_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgCompat(cfgCompat),
    .cfgKeeper(cfgKeeper), .cfgSplitAddr(cfgSplitAddr), .cfgWaitLo(cfgWaitLo),
    .cfgWaitHi(cfgWaitHi), .cfgHiBits(cfgHiBits), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuStall(cpuStall),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .adKeep(adKeep), .hiAddr(hiAddr),
    .hiOe(hiOe), .ale(ale), .rdN(rdN), .wrN(wrN), .portOverride(portOverride)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] addr, input bit we, input logic [7:0] wd);
    bit ext, intl;
    int n, k;
    logic [7:0] mask, rdExp, lastDrv;
    ext  = cfgEnable && (addr > 16'h10FF);
    intl = cfgEnable && !ext;
    if (cfgCompat) n = cfgWaitLo[0];
    else if (addr >= cfgSplitAddr) n = cfgWaitHi;
    else n = cfgWaitLo;
    if (!ext) n = 0;
    k = cfgCompat ? 8 : ((cfgHiBits > 8) ? 8 : int'(cfgHiBits));
    mask = 8'((9'd1 << k) - 1);
    rdExp = addr[7:0] ^ addr[15:8] ^ 8'h5A;
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd; adIn = rdExp;
    @(negedge clk);
    cpuReq = 1'b0;
    if (!cfgEnable) begin
      // R9: no bus cycle at any address while disabled
      chk(!ale && rdN && wrN && !adOe && hiOe == 0 && !cpuStall && !portOverride,
          "R9", "disabled bus activity", {ale, rdN, wrN, adOe, cpuStall, portOverride}, 6'b011000);
      @(negedge clk);
      chk(!ale && !adOe && !cpuStall, "R9", "disabled second cycle", {ale, adOe, cpuStall}, 0);
      return;
    end
    // R3 address phase
    chk(ale && adOe && adOut == addr[7:0], "R3", "address phase bus", {ale, adOe, adOut}, {2'b11, addr[7:0]});
    chk(hiAddr == (addr[15:8] & mask) && hiOe == mask, "R11", "upper bus/mask",
        {hiAddr, hiOe}, {addr[15:8] & mask, mask});
    chk(rdN && wrN, "R2", "no strobe in address phase", {rdN, wrN}, 2'b11);
    chk(cpuStall == ext, "R7", "stall in address phase", cpuStall, ext);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      chk(!ale, "R4", "latch enable low in data phase", ale, 0);
      chk(cpuStall == ext, intl ? "R8" : "R7", "stall in strobe phase", cpuStall, ext);
      if (we) begin
        chk(adOe && adOut == wd, "R4", "write data on bus", {adOe, adOut}, {1'b1, wd});
        chk(wrN == !ext && rdN, ext ? "R4" : "R8", "write strobe", {wrN, rdN}, {!ext, 1'b1});
      end else begin
        chk(!adOe, "R5", "bus released in read", adOe, 0);
        chk(rdN == !ext && wrN, ext ? "R5" : "R8", "read strobe", {rdN, wrN}, {!ext, 1'b1});
      end
    end
    @(negedge clk);
    // turnaround cycle: strobe count ends exactly after 1+N cycles (R6/R10)
    chk(rdN && wrN, cfgCompat ? "R10" : "R6", "strobe length 1+N", {rdN, wrN}, 2'b11);
    chk(!cpuStall && !adOe, "R7", "turnaround release", {cpuStall, adOe}, 0);
    if (ext && !we) chk(cpuRdata == rdExp, "R5", "read data capture", cpuRdata, rdExp);
    lastDrv = we ? wd : addr[7:0];
    chk(adOut == lastDrv, "R12", "keeper holds last value", adOut, lastDrv);
    chk(adKeep == (cfgKeeper && !cfgCompat), "R12", "keeper indication", adKeep, cfgKeeper && !cfgCompat);
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] addrs [8];
    addrs[0] = 16'h0000; addrs[1] = 16'h10FF; addrs[2] = 16'h1100; addrs[3] = 16'h7FFF;
    addrs[4] = 16'h8000; addrs[5] = 16'hFFFF; addrs[6] = 16'hA5C3; addrs[7] = 16'h3C5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ale && rdN && wrN && !adOe && !cpuStall && cpuRdata == 0, "R1", "reset outputs",
        {ale, rdN, wrN, adOe, cpuStall, cpuRdata}, {5'b01100, 8'h00});
    rstN = 1'b1;
    @(negedge clk);
    cfgEnable = 1'b0;
    for (int a = 0; a < 8; a++) access(addrs[a], a[0], 8'(a * 37));
    cfgEnable = 1'b1;
    for (int c = 0; c < 2; c++)
      for (int lo = 0; lo < 4; lo++)
        for (int hi = 0; hi < 4; hi++) begin
          cfgCompat = c[0];
          cfgWaitLo = lo[1:0];
          cfgWaitHi = hi[1:0];
          cfgHiBits = 4'((lo * 4 + hi) % 10);
          cfgKeeper = hi[0];
          for (int a = 0; a < 8; a++)
            for (int w = 0; w < 2; w++)
              access(addrs[a], w[0], 8'(a * 29 + lo * 7 + hi + 1));
        end
    // sector edge just below split
    cfgCompat = 1'b0; cfgWaitLo = 2'd0; cfgWaitHi = 2'd3; cfgSplitAddr = 16'h4000;
    access(16'h3FFF, 1'b0, 8'h00);
    access(16'h4000, 1'b0, 8'h00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule